// File: doc/BRIEF.md
# Bidirectional 64-Channel Column Driver Core

This block is the digital core of one column driver for a display panel. It holds a 64-stage serial chain and loads it four bits per clock through one of two 4-bit data ports. The chain is built from four 16-deep lanes that are interleaved. Lane k holds stages k, k+4, k+8 and so on up to k+60. Every rising clock edge moves all data four stage positions along the chain. A direction input picks which port feeds data in and which port passes the far end of the chain on to the next device. When the direction is reversed, the two ports swap these roles. Several cores can be cascaded by linking the B side of one to the A side of the next, giving 128, 192, 320 or more columns.

On any edge where the latch-enable input is high, a 64-bit latch takes a snapshot of the chain. An output stage then drives the 64 driver-level outputs from that latch. A blank input forces every output to one common level. An active-low polarity input inverts the whole display when it is low. If only three of the four lanes are fed, the core drives a 48-column subset of each group.

Top module: `bidir_coldrv`

## Requirements
- R1: With `rst` high at a rising edge, the chain, the latch and `drv_out` all become zero.
- R2: With `dir_right` high, each edge loads `a_in[k-1]` into stage k (k = 1..4). Every other stage s takes the value of stage s-4. `b_out[k-1]` always shows stage 60+k.
- R3: With `dir_right` low, each edge loads `b_in[k-1]` into stage 60+k. Every other stage s takes the value of stage s+4. `a_out[k-1]` always shows stage k.
- R4: `a_oe` equals the inverse of `dir_right` and `b_oe` equals `dir_right`, so the port acting as input is never driven.
- R5: If `latch_en` is high at an edge, the latch takes the chain contents as they stood before that edge's shift. If `latch_en` is low, the latch is unchanged.
- R6: If `blank` is high at an edge, then after that edge all 64 bits of `drv_out` equal the value that `pol_n` had at that edge.
- R7: If `blank` is low at an edge, then after that edge `drv_out[s-1]` equals latch bit s-1 as held before the edge. This bit is inverted when `pol_n` was low.
- R8: When two cores are linked (B outputs to A inputs and A outputs to B inputs), data entering one end reaches the second core's far-end port 32 edges later, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_right | input | 1 | 1: shift toward stage 64, 0: shift toward stage 1 |
| latch_en | input | 1 | Capture the chain into the latch at this edge |
| blank | input | 1 | Force all outputs to the polarity level |
| pol_n | input | 1 | Active-low global output inversion |
| a_in | input | 4 | A-side data input (used when shifting right) |
| a_out | output | 4 | A-side cascade output, stages 1..4 |
| a_oe | output | 1 | Drive enable for the A side |
| b_in | input | 4 | B-side data input (used when shifting left) |
| b_out | output | 4 | B-side cascade output, stages 61..64 |
| b_oe | output | 1 | Drive enable for the B side |
| drv_out | output | 64 | Driver-level outputs, bit s-1 for column s |

## Verification
The port enables follow `dir_right` with no delay. A shift shows on the cascade ports right after the edge that performs it. A latch capture at edge N reaches `drv_out` only after edge N+1, because the output gate adds a register. Changes to `blank` and `pol_n` show after the next edge. The bench drives all inputs just after a falling edge and updates its behavioural model with the values present at the coming rising edge. It then compares every output of both cascaded cores at the following falling edge. This keeps each one-edge and two-edge delay exact. A wrong stage in the pipeline shows up as a mismatch in the very cycle it occurs.

// File: rtl/drvcol_pkg.sv
package drvcol_pkg;

  typedef enum logic {
    SHIFT_LEFT  = 1'b0,
    SHIFT_RIGHT = 1'b1
  } shift_dir_e;

  // Driver level for one column: blank overrides, else latch with optional inversion.
  function automatic logic gate_level(input logic lat_bit, input logic blank,
                                      input logic pol_n);
    if (blank) return pol_n;
    return lat_bit ^ ~pol_n;
  endfunction

endpackage

// File: rtl/drvcol_lane.sv
module drvcol_lane #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_right,
  input  logic             head_in,
  input  logic             tail_in,
  output logic [DEPTH-1:0] q
);
  import drvcol_pkg::*;

  shift_dir_e dir;
  assign dir = shift_dir_e'(dir_right);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (dir == SHIFT_RIGHT) begin
      q <= {q[DEPTH-2:0], head_in};
    end else begin
      q <= {tail_in, q[DEPTH-1:1]};
    end
  end

  // R2: right shift loads the head and advances toward the tail
  a_r2_head_entry: assert property (@(posedge clk) disable iff (rst)
    dir_right |=> q[0] == $past(head_in));
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    dir_right |=> q[DEPTH-1:1] == $past(q[DEPTH-2:0]));
  // R3: left shift loads the tail and advances toward the head
  a_r3_tail_entry: assert property (@(posedge clk) disable iff (rst)
    !dir_right |=> q[DEPTH-1] == $past(tail_in));
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    !dir_right |=> q[DEPTH-2:0] == $past(q[DEPTH-1:1]));

endmodule

// File: rtl/drvcol_chain.sv
module drvcol_chain #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int STAGES = LANES * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_right,
  input  logic [LANES-1:0]  a_in,
  input  logic [LANES-1:0]  b_in,
  output logic [LANES-1:0]  a_out,
  output logic [LANES-1:0]  b_out,
  output logic [STAGES-1:0] stages
);
  logic [DEPTH-1:0] lane_q [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    drvcol_lane #(.DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .dir_right (dir_right),
      .head_in   (a_in[k]),
      .tail_in   (b_in[k]),
      .q         (lane_q[k])
    );
    assign a_out[k] = lane_q[k][0];
    assign b_out[k] = lane_q[k][DEPTH-1];
    // Interleave: stage index p*LANES+k (0-based) lives in lane k position p.
    for (genvar p = 0; p < DEPTH; p++) begin : g_pos
      assign stages[p*LANES + k] = lane_q[k][p];
    end
  end

endmodule

// File: rtl/drvcol_latch.sv
module drvcol_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         latch_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (latch_en) q <= d;
  end

  // R5: capture of pre-shift chain, hold otherwise
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> q == $past(d));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(q));

endmodule

// File: rtl/drvcol_gate.sv
module drvcol_gate #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blank,
  input  logic         pol_n,
  input  logic [W-1:0] lat,
  output logic [W-1:0] drv
);
  import drvcol_pkg::*;

  logic [W-1:0] drv_d;

  for (genvar i = 0; i < W; i++) begin : g_col
    assign drv_d[i] = gate_level(lat[i], blank, pol_n);
  end

  always_ff @(posedge clk) begin
    if (rst) drv <= '0;
    else     drv <= drv_d;
  end

  // R6: blank forces one common level equal to the polarity pin
  a_r6_blank_level: assert property (@(posedge clk) disable iff (rst)
    blank |=> (drv == {W{$past(pol_n)}}));
  // R7: unblanked output tracks the latch, inverted when pol_n is low
  a_r7_follow: assert property (@(posedge clk) disable iff (rst)
    !blank |=> (drv == ($past(lat) ^ {W{!$past(pol_n)}})));

endmodule

// File: rtl/bidir_coldrv.sv
module bidir_coldrv #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int W = LANES * DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_right,
  input  logic             latch_en,
  input  logic             blank,
  input  logic             pol_n,
  input  logic [LANES-1:0] a_in,
  output logic [LANES-1:0] a_out,
  output logic             a_oe,
  input  logic [LANES-1:0] b_in,
  output logic [LANES-1:0] b_out,
  output logic             b_oe,
  output logic [W-1:0]     drv_out
);

  logic [W-1:0] chain_q;
  logic [W-1:0] latch_q;

  assign a_oe = ~dir_right;
  assign b_oe = dir_right;

  drvcol_chain #(.LANES(LANES), .DEPTH(DEPTH)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .dir_right (dir_right),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .b_out     (b_out),
    .stages    (chain_q)
  );

  drvcol_latch #(.W(W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .d        (chain_q),
    .q        (latch_q)
  );

  drvcol_gate #(.W(W)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .blank (blank),
    .pol_n (pol_n),
    .lat   (latch_q),
    .drv   (drv_out)
  );

  // R1: reset clears outputs and chain ends
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (drv_out == '0) && (a_out == '0) && (b_out == '0));
  // R4: exactly one side drives
  always_comb begin
    a_r4_one_side: assert ($onehot({a_oe, b_oe}) || $isunknown(dir_right));
  end

endmodule

// File: tb/bidir_coldrv_tb.sv
module bidir_coldrv_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, dir_right, latch_en, blank, pol_n;
  logic [3:0] a_in0, b_in1;
  logic [3:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;
  logic [63:0] drv0, drv1;

  bidir_coldrv u_dut (
    .clk(clk), .rst(rst), .dir_right(dir_right), .latch_en(latch_en),
    .blank(blank), .pol_n(pol_n),
    .a_in(a_in0), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(a_out1), .b_out(b_out0), .b_oe(b_oe0),
    .drv_out(drv0));

  bidir_coldrv u_dut2 (
    .clk(clk), .rst(rst), .dir_right(dir_right), .latch_en(latch_en),
    .blank(blank), .pol_n(pol_n),
    .a_in(b_out0), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in1), .b_out(b_out1), .b_oe(b_oe1),
    .drv_out(drv1));

  int checks = 0;
  int errors = 0;
  logic [63:0] m0 = '0, m1 = '0, l0 = '0, l1 = '0, d0 = '0, d1 = '0;

  function automatic logic [63:0] shift_model(logic [63:0] c, logic right,
                                              logic [3:0] ai, logic [3:0] bi);
    logic [63:0] n;
    for (int s = 1; s <= 64; s++) begin
      if (right) n[s-1] = (s <= 4)  ? ai[s-1]  : c[s-5];
      else       n[s-1] = (s >= 61) ? bi[s-61] : c[s+3];
    end
    return n;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic r, logic d, logic le, logic bl, logic pn,
                      logic [3:0] ai, logic [3:0] bi);
    logic [63:0] n0, n1;
    rst = r; dir_right = d; latch_en = le; blank = bl; pol_n = pn;
    a_in0 = ai; b_in1 = bi;
    if (r) begin
      m0 = '0; m1 = '0; l0 = '0; l1 = '0; d0 = '0; d1 = '0;
    end else begin
      n0 = shift_model(m0, d, ai, m1[3:0]);
      n1 = shift_model(m1, d, m0[63:60], bi);
      d0 = bl ? {64{pn}} : (l0 ^ {64{~pn}});
      d1 = bl ? {64{pn}} : (l1 ^ {64{~pn}});
      if (le) begin l0 = m0; l1 = m1; end
      m0 = n0; m1 = n1;
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      check("R1 drv0", drv0, 64'h0);
      check("R1 drv1", drv1, 64'h0);
    end else begin
      check(bl ? "R6 drv0" : "R5 R7 drv0", drv0, d0);
      check(bl ? "R6 drv1" : "R5 R7 drv1", drv1, d1);
    end
    check(d ? "R2 b_out0" : "R3 a_out0", d ? {60'h0, b_out0} : {60'h0, a_out0},
          d ? {60'h0, m0[63:60]} : {60'h0, m0[3:0]});
    check(d ? "R8 b_out1" : "R8 a_out1", d ? {60'h0, b_out1} : {60'h0, a_out1},
          d ? {60'h0, m1[63:60]} : {60'h0, m1[3:0]});
    check("R4 oe", {60'h0, a_oe0, b_oe0, a_oe1, b_oe1}, {60'h0, ~d, d, ~d, d});
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; dir_right = 1'b1; latch_en = 1'b0; blank = 1'b0; pol_n = 1'b1;
    a_in0 = '0; b_in1 = '0;
    @(negedge clk);
    step(1, 1, 0, 0, 1, 4'h0, 4'h0);   // R1
    step(1, 0, 1, 1, 0, 4'hF, 4'hF);   // R1

    // R2 / R8: fill both cores to the right, latch, then all blank/polarity cases
    for (int i = 0; i < 32; i++)
      step(0, 1, 0, 1, 0, 4'(i) ^ 4'hA, 4'h3);
    step(0, 1, 1, 0, 1, 4'h6, 4'h0);    // R5 capture
    step(0, 1, 0, 0, 1, 4'h1, 4'h0);    // R7 normal
    step(0, 1, 0, 0, 0, 4'h2, 4'h0);    // R7 inverted
    step(0, 1, 0, 1, 1, 4'h3, 4'h0);    // R6 high
    step(0, 1, 0, 1, 0, 4'h4, 4'h0);    // R6 low
    step(0, 1, 0, 0, 1, 4'h5, 4'h0);    // R5 hold

    // R3 / R8: fill to the left
    for (int i = 0; i < 32; i++)
      step(0, 0, 0, 0, 1, 4'h9, 4'(i * 5) ^ 4'h6);
    step(0, 0, 1, 0, 1, 4'h0, 4'hC);
    step(0, 0, 0, 0, 0, 4'h0, 4'h3);
    step(0, 0, 0, 1, 1, 4'h0, 4'h5);
    step(0, 0, 0, 1, 0, 4'h0, 4'hA);
    step(0, 0, 0, 0, 1, 4'h0, 4'h1);

    // Mixed stimulus, direction changes at any cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(i == 200, lfsr[0] | lfsr[7], lfsr[3] & lfsr[5], lfsr[1] & lfsr[9],
           lfsr[2] | lfsr[11], lfsr[15:12], lfsr[11:8]);
    end
    summary();
    $finish;
  end
endmodule